// File: doc/BRIEF.md
# Double-Buffered PWM Channel

A single pulse-width-modulated output channel. Software writes a period value and a pulse-width value into two registers it can read back. The counter never uses those registers directly. It uses a pair of working copies, and these are refreshed from the visible registers only at a period boundary, when the channel is enabled, or on a forced load. Software can therefore prepare the next period's shape at any time without disturbing the current one.

A sticky completion flag tells software when the working copies have taken new values, which means the visible registers are free for the next update. The flag is set when the channel is enabled and at every period wrap. It stays set until software reads it as one and then writes a zero to it. A three-bit level field gates an interrupt request from the flag. The counter advances only on cycles where a selected one of eight prescaled tick inputs is high.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After reset the control word (address 0), the period register (address 1) and the width register (address 2) all read zero, and `pwm_out` and `irq_o` are low.
- R2: While enabled, the counter runs 0 to P-1 and then wraps, where P is the working period (a period of 0 behaves as 1). The internal level is active while the count is below the working width W. W = 0 is never active, and W >= P is always active.
- R3: Control bit 4 inverts the pin: `pwm_out` equals the active level XOR bit 4. While disabled, the internal level is inactive, so the pin equals bit 4.
- R4: A write to the period or width register takes effect only at the next period wrap. The remainder of the current period keeps the old working values.
- R5: Writing control bit 3 (enable) from 0 to 1 loads both working copies, restarts the counter at 0 and sets the flag on that same edge.
- R6: The flag (control bit 15) is set on every period wrap. Once set, it stays set through later wraps and through any write that does not clear it.
- R7: Writing bit 15 as 0 clears the flag only if a read of the control word returned the flag as 1 and no other control write came in between. Writing bit 15 as 1 never changes the flag.
- R8: If a period wrap falls between the arming read and the clearing write, the flag stays set.
- R9: Writing control bit 5 as 1 copies the visible registers into the working copies at once and restarts the counter at 0, without setting the flag. Bit 5 always reads as 0.
- R10: Control bits 2:0 select which bit of `tick_in` advances the counter. On cycles where that bit is 0, the count holds.
- R11: `irq_o` is high exactly while the flag is set and control bits 14:12 are nonzero.
- R12: Control bit 7 reads back the current `pwm_out` level. Bit 11 is a plain read/write bit. Bits 10:8 and 6 read 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a control read with this high can arm a flag clear |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| tick_in | input | 8 | Prescaled count-enable pulses, one chosen by bits 2:0 |
| pwm_out | output | 1 | PWM pin |
| irq_o | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. The count stays below the working period. The working copies change only on a start, a load or a wrap. The count holds when the selected tick is low. A flag rise is always traced to a start or a wrap, and a flag fall to a zero write. The disabled pin sits at the polarity level, the load bit reads zero, and no interrupt is raised without the flag. The bench scenarios cover the things a single cycle cannot show: active-cycle counts across whole periods for many period, width and polarity combinations; the old width persisting after a mid-period write; the read-then-write clearing order and its loss to an intervening wrap; and a forced load leaving the flag clear.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int SEL_W  = 3;
    localparam int NSEL   = 1 << SEL_W;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_PER  = 2'd1;
    localparam logic [ADDR_W-1:0] A_WID  = 2'd2;

    localparam int B_FLAG = 15;
    localparam int B_LVL  = 12;
    localparam int B_ARB  = 11;
    localparam int B_PIN  = 7;
    localparam int B_LOAD = 5;
    localparam int B_POL  = 4;
    localparam int B_EN   = 3;

    typedef struct packed {
        logic [2:0]       lvl;
        logic             arb;
        logic             pol;
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctrl_t;
endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              pin_i,
    input  logic              wrap_i,
    output logic [DATA_W-1:0] rdata_o,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  per_o,
    output logic [CNT_W-1:0]  wid_o,
    output logic              start_o,
    output logic              load_o,
    output logic              flag_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic             flag;
        logic             armed;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] wid;
    } regs_t;

    regs_t s_d, s_q;
    logic  wr_ctrl, set_ev;
    logic  unused_wbits;

    assign unused_wbits = ^{bus_wdata[10:6]};

    always_comb begin
        s_d     = s_q;
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        start_o = 1'b0;
        load_o  = 1'b0;
        if (wr_ctrl) begin
            s_d.ctrl.lvl = bus_wdata[B_LVL +: 3];
            s_d.ctrl.arb = bus_wdata[B_ARB];
            s_d.ctrl.pol = bus_wdata[B_POL];
            s_d.ctrl.en  = bus_wdata[B_EN];
            s_d.ctrl.sel = bus_wdata[SEL_W-1:0];
            start_o      = bus_wdata[B_EN] && !s_q.ctrl.en;
            load_o       = bus_wdata[B_LOAD];
        end
        if (bus_wr && (bus_addr == A_PER)) s_d.per = bus_wdata[CNT_W-1:0];
        if (bus_wr && (bus_addr == A_WID)) s_d.wid = bus_wdata[CNT_W-1:0];

        set_ev = start_o || wrap_i;
        if (wr_ctrl && !bus_wdata[B_FLAG] && s_q.armed) s_d.flag = 1'b0;
        if (set_ev) s_d.flag = 1'b1;

        if (bus_rd && (bus_addr == A_CTRL) && s_q.flag) s_d.armed = 1'b1;
        if (wr_ctrl || set_ev) s_d.armed = 1'b0;

        rdata_o = '0;
        case (bus_addr)
            A_CTRL: begin
                rdata_o[B_FLAG]       = s_q.flag;
                rdata_o[B_LVL +: 3]   = s_q.ctrl.lvl;
                rdata_o[B_ARB]        = s_q.ctrl.arb;
                rdata_o[B_PIN]        = pin_i;
                rdata_o[B_POL]        = s_q.ctrl.pol;
                rdata_o[B_EN]         = s_q.ctrl.en;
                rdata_o[SEL_W-1:0]    = s_q.ctrl.sel;
            end
            A_PER:   rdata_o[CNT_W-1:0] = s_q.per;
            A_WID:   rdata_o[CNT_W-1:0] = s_q.wid;
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o = s_q.ctrl;
    assign per_o  = s_q.per;
    assign wid_o  = s_q.wid;
    assign flag_o = s_q.flag;

    // R6: once set, the flag survives any cycle without a zero write
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.flag && !(wr_ctrl && !bus_wdata[B_FLAG]) |=> s_q.flag);

    // R6: a flag rise is caused by a start or by a wrap from the counter
    a_r6_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> $past(start_o || wrap_i));

    // R7: a flag fall needs a control write with bit 15 low
    a_r7_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.flag) |-> $past(wr_ctrl && !bus_wdata[B_FLAG]));
endmodule

// File: rtl/pwm_dbuf_core.sv
module pwm_dbuf_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             load_i,
    input  logic             pol_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] wid_i,
    output logic             wrap_o,
    output logic             pin_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per_w;
        logic [CNT_W-1:0] wid_w;
    } core_t;

    core_t         c_d, c_q;
    logic [CNT_W:0] cnt_inc;
    logic          at_last;

    always_comb begin
        c_d     = c_q;
        wrap_o  = 1'b0;
        cnt_inc = {1'b0, c_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        at_last = cnt_inc >= {1'b0, c_q.per_w};
        if (start_i || load_i) begin
            c_d.cnt   = '0;
            c_d.per_w = per_i;
            c_d.wid_w = wid_i;
        end else if (!en_i) begin
            c_d.cnt = '0;
        end else if (tick_i) begin
            if (at_last) begin
                wrap_o    = 1'b1;
                c_d.cnt   = '0;
                c_d.per_w = per_i;
                c_d.wid_w = wid_i;
            end else begin
                c_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
        pin_o = (en_i && (c_q.cnt < c_q.wid_w)) ^ pol_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R2: count stays inside the working period
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.per_w == '0) ? (c_q.cnt == '0) : (c_q.cnt < c_q.per_w));

    // R4: working copies move only on start, load or wrap
    a_r4_work_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i || load_i || wrap_o) |=> $stable(c_q.per_w) && $stable(c_q.wid_w));

    // R10: no selected tick, no count change
    a_r10_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !tick_i && !start_i && !load_i |=> $stable(c_q.cnt));
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSEL-1:0]   tick_in,
    output logic              pwm_out,
    output logic              irq_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] per_vis, wid_vis;
    logic             start, load, wrap, flag;

    pwm_dbuf_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .pin_i     (pwm_out),
        .wrap_i    (wrap),
        .rdata_o   (bus_rdata),
        .ctrl_o    (ctrl),
        .per_o     (per_vis),
        .wid_o     (wid_vis),
        .start_o   (start),
        .load_o    (load),
        .flag_o    (flag)
    );

    pwm_dbuf_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (ctrl.en),
        .tick_i  (tick_in[ctrl.sel]),
        .start_i (start),
        .load_i  (load),
        .pol_i   (ctrl.pol),
        .per_i   (per_vis),
        .wid_i   (wid_vis),
        .wrap_o  (wrap),
        .pin_o   (pwm_out)
    );

    assign irq_o = flag && (ctrl.lvl != 3'd0);

    // R9: the load bit never reads back as one
    a_r9_load_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_addr == A_CTRL) |-> !bus_rdata[B_LOAD]);

    // R3: a disabled channel drives the polarity level
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> (pwm_out == ctrl.pol));

    // R11: no request without the flag
    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq_o);
endmodule

// File: tb/sim_pwm_dbuf_chan.sv
module sim_pwm_dbuf_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [7:0]  tick_in = 8'b0000_0001;
    logic        pwm_out;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    localparam logic [15:0] EN   = 16'h0008;
    localparam logic [15:0] POL  = 16'h0010;
    localparam logic [15:0] LOAD = 16'h0020;
    localparam logic [15:0] FLG  = 16'h8000;
    localparam logic [15:0] LV3  = 16'h3000;

    // period, width, polarity, expected active-high samples over two periods
    localparam int NVEC = 8;
    localparam int VEC [NVEC][4] = '{
        '{10, 3, 0, 6}, '{10, 0, 0, 0}, '{10, 10, 0, 20}, '{10, 15, 0, 20},
        '{8, 5, 1, 6},  '{1, 1, 0, 2},  '{5, 0, 1, 10},   '{4, 2, 0, 4}
    };

    pwm_dbuf_chan u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tick_in(tick_in), .pwm_out(pwm_out), .irq_o(irq_o)
    );

    always #10 clk = ~clk;
    always @(negedge clk) tick_in[1] <= ~tick_in[1];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        repeat (n) begin
            if (pwm_out) h++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pin", int'(pwm_out), 0);
        chk("R1 irq", int'(irq_o), 0);
        rd(2'd0, d); chk("R1 ctrl", int'(d), 0);
        rd(2'd1, d); chk("R1 period", int'(d), 0);
        rd(2'd2, d); chk("R1 width", int'(d), 0);

        // R2 R3 R5: vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd0, 16'h0000);
            wr(2'd1, 16'(VEC[i][0]));
            wr(2'd2, 16'(VEC[i][1]));
            wr(2'd0, EN | (VEC[i][2] != 0 ? POL : 16'h0));
            count_high(2 * VEC[i][0], h);
            chk($sformatf("R2/R3 vec%0d", i), h, VEC[i][3]);
            rd(2'd0, d); chk("R5 flag after enable", int'(d[15]), 1);
        end

        // R4 double buffering: mid-period width write
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd10);
        wr(2'd2, 16'd3);
        wr(2'd0, EN);
        wr(2'd2, 16'd7);          // returns at count 2
        count_high(8, h);  chk("R4 old width rest of period", h, 1);
        count_high(10, h); chk("R4 new width next period", h, 7);

        // R6 R7 R11 flag clearing
        wr(2'd1, 16'd40);
        wr(2'd0, FLG | EN | LOAD);
        rd(2'd0, d); chk("R6 flag set", int'(d[15]), 1);
        wr(2'd0, EN);
        rd(2'd0, d); chk("R7 cleared after read-one", int'(d[15]), 0);
        wr(2'd0, FLG | LV3 | EN);
        chk("R7 write one no set", int'(irq_o), 0);
        repeat (45) @(negedge clk);
        chk("R11 irq on wrap", int'(irq_o), 1);
        rd(2'd0, d);
        chk("R6 flag after wrap", int'(d[15]), 1);
        chk("R12 level field", int'(d[14:12]), 3);
        wr(2'd0, FLG | LV3 | EN | LOAD);
        wr(2'd0, LV3 | EN);
        chk("R7 no clear without read", int'(irq_o), 1);

        // R8 wrap between read and write
        rd(2'd0, d);
        repeat (45) @(negedge clk);
        wr(2'd0, LV3 | EN);
        chk("R8 wrap defeats clear", int'(irq_o), 1);

        // R9 forced load
        wr(2'd0, FLG | LV3 | EN | LOAD);
        rd(2'd0, d);
        wr(2'd0, LV3 | EN);
        chk("R11 irq drops with flag", int'(irq_o), 0);
        wr(2'd1, 16'd6);
        wr(2'd2, 16'd2);
        wr(2'd0, FLG | LV3 | EN | LOAD);
        chk("R9 load leaves flag clear", int'(irq_o), 0);
        rd(2'd0, d);              // returns at count 2
        chk("R9 load reads zero", int'(d[5]), 0);
        count_high(4, h); chk("R9 immediate width", h, 0);
        count_high(6, h); chk("R9 immediate period", h, 2);

        // R5 enable sets the flag at once
        wr(2'd0, LV3);
        rd(2'd0, d);
        wr(2'd0, LV3);
        chk("R5 flag cleared while idle", int'(irq_o), 0);
        wr(2'd0, LV3 | EN);
        chk("R5 flag on enable", int'(irq_o), 1);

        // R10 clock select
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd1);
        wr(2'd0, EN | 16'h0001);
        count_high(16, h); chk("R10 half-rate tick", h, 4);
        wr(2'd0, EN | 16'h0002);
        count_high(10, h); chk("R10 frozen on idle tick", int'(h == 0 || h == 10), 1);

        // R3 R12 idle level, readback, unused
        wr(2'd0, POL);
        chk("R3 idle at polarity", int'(pwm_out), 1);
        rd(2'd0, d); chk("R12 pin readback word", int'(d & 16'h7FFF), 16'h0090);
        wr(2'd0, 16'h0F40);
        rd(2'd0, d); chk("R12 arb bit only", int'(d & 16'h7FFF), 16'h0800);
        chk("R3 idle low", int'(pwm_out), 0);
        rd(2'd3, d); chk("R12 address 3", int'(d), 0);
        rd(2'd1, d); chk("R12 period readback", int'(d), 4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule